// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block gathers interrupt requests from up to 31 peripheral lines, numbered 1 to 31, and drives one active-low request line to the processor. Every source has its own 3-bit priority, an enable bit, a choice between edge and level triggering, and a handler vector. All of these are written over a small word-addressed register bus. Software takes an interrupt by reading the vector port. That read picks the winning source at that moment, returns its stored vector and makes it the interrupt in service. Software ends the handler by writing the end-of-interrupt port.

The block allows nesting. On every acknowledge, the interrupted context (source number and level) is saved on an 8-entry hardware stack. The request line is raised only for a priority strictly above the one in service. An end-of-interrupt write restores the saved context. A nesting state machine follows how full the stack is. It has three states: IDLE (nothing in service, stack empty), SERVICE (1 to 7 entries) and FULL (8 entries). It has five transitions: ACK_FIRST (IDLE to SERVICE), ACK_NEST (SERVICE to SERVICE, or SERVICE to FULL on the eighth push), EOI_NEST (SERVICE to SERVICE), EOI_LAST (SERVICE to IDLE when the last entry pops) and EOI_FULL (FULL to SERVICE).

The bus address is split into fields. Address bits [6:5] select a region: 0 is the mode words, 1 is the vector words, 2 is the control ports. Bits [4:0] give the source number, or the control port: 0 vector/acknowledge, 1 end-of-interrupt, 2 spurious vector, 3 status. A mode word holds the priority in [2:0], edge triggering in bit 4 (1 = rising edge, 0 = active-high level) and enable in bit 8. The status word holds the current source in [4:0], the current priority in [10:8], an in-service flag in bit 12 and the stack depth in [19:16]. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`, and it holds until the next read.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is high, the status word reads 0 (nothing in service, depth 0), and a vector read returns the spurious vector, whose reset value is 0.
- R2: Once an enabled source has an active condition and a priority above the current level, `irq_n` goes low within three clock cycles of the input change.
- R3: A source whose enable bit (mode bit 8) is 0 never lowers `irq_n` and is never returned by a vector read.
- R4: The winner is chosen when the vector port is read. A higher-priority source that becomes active after `irq_n` fell wins over the source that caused the request.
- R5: Among enabled pending sources that share the highest priority, the lowest source number is returned.
- R6: A vector read returns the vector word stored for the selected source. The mode and vector words read back as written.
- R7: A successful acknowledge saves the previous context on the stack, makes the selected source current and adds one to the status depth.
- R8: While a source is in service, requests at or below its priority keep `irq_n` high. A request at a strictly higher priority lowers it again.
- R9: An end-of-interrupt write restores the previously saved source and priority. Requests that were held off then raise `irq_n` again.
- R10: An edge source (mode bit 4 = 1) latches on a rising input and stays pending after the input falls, until it is acknowledged. A level source is pending only while its input is high.
- R11: A vector read with no eligible source returns the spurious vector (control port 2) and leaves the stack depth unchanged.
- R12: An end-of-interrupt write on an empty stack changes nothing. The stack nests to eight levels, and a push onto a full stack is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Interrupt inputs, bit n is source n (bit 0 has no source) |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 7 | Word address: region in [6:5], source or port in [4:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
Level sources are held active through an acknowledge and an end-of-interrupt. This separates held-off requests that come back (level) from ones that were consumed (edge, single pulse). Equal-priority groups test the lowest-number rule. A late, higher-priority arrival tests choice at read time rather than at request time. A strictly rising ladder of eight priorities fills the stack and shows restoration in reverse order. Reads with nothing eligible, with a disabled source, with the stack full and with an empty stack expose the spurious-vector and ignore paths.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // bus regions, decoded from the two top address bits
    localparam logic [1:0] RG_MODE = 2'd0;
    localparam logic [1:0] RG_VEC  = 2'd1;
    localparam logic [1:0] RG_CTRL = 2'd2;

    // control ports inside RG_CTRL
    localparam int CTL_IVR    = 0;
    localparam int CTL_EOI    = 1;
    localparam int CTL_SPUR   = 2;
    localparam int CTL_STATUS = 3;

    // mode word fields
    localparam int MODE_EDGE_BIT = 4;
    localparam int MODE_EN_BIT   = 8;

    // status word fields
    localparam int ST_PRIO_LSB  = 8;
    localparam int ST_VALID_BIT = 12;
    localparam int ST_DEPTH_LSB = 16;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERVICE = 2'd1,
        ST_FULL    = 2'd2
    } nest_state_t;

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               src_in,
    input  logic                             wr_mode,
    input  logic                             wr_vec,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             clr_en,
    input  logic [IDX_W-1:0]                 clr_idx,
    output logic [NUM_SRC-1:0]               req_o,
    output logic [NUM_SRC-1:0]               en_o,
    output logic [NUM_SRC-1:0]               edge_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   vec_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic              src_q;
        logic              pend_q;
        logic              en_q;
        logic              edge_q;
        logic [PRIO_W-1:0] prio_q;
        logic [DATA_W-1:0] vec_q;
        logic              sel_w;
        logic              rise_w;
        logic              clr_w;

        assign sel_w  = (wr_idx == IDX_W'(i));
        assign rise_w = src_in[i] & ~src_q;
        assign clr_w  = clr_en && (clr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q  <= 1'b0;
                pend_q <= 1'b0;
                en_q   <= 1'b0;
                edge_q <= 1'b0;
                prio_q <= '0;
                vec_q  <= '0;
            end else begin
                src_q <= src_in[i];
                if (wr_mode && sel_w) begin
                    prio_q <= wr_data[PRIO_W-1:0];
                    edge_q <= wr_data[MODE_EDGE_BIT];
                    // index 0 carries no source and can never be enabled
                    en_q   <= (i != 0) && wr_data[MODE_EN_BIT];
                end
                if (wr_vec && sel_w) begin
                    vec_q <= wr_data;
                end
                if (!en_q || !edge_q) begin
                    pend_q <= 1'b0;
                end else if (rise_w) begin
                    pend_q <= 1'b1;
                end else if (clr_w) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign req_o[i]  = en_q & (edge_q ? pend_q : src_q);
        assign en_o[i]   = en_q;
        assign edge_o[i] = edge_q;
        assign prio_o[i] = prio_q;
        assign vec_o[i]  = vec_q;

        AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w && en_q && edge_q && !rise_w && !wr_mode) |=> !pend_q) else $error("edge pending survived acknowledge"); // R10
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int LVL_W  = PRIO_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [LVL_W-1:0]               cur_lvl,
    output logic                           win_valid,
    output logic [IDX_W-1:0]               win_idx,
    output logic [LVL_W-1:0]               win_lvl
);

    // level encoding: 0 means "nothing", priority p maps to p+1
    function automatic logic [LVL_W-1:0] to_lvl(input logic [PRIO_W-1:0] p);
        return LVL_W'(p) + LVL_W'(1);
    endfunction

    logic [LVL_W-1:0] best_lvl;
    logic [IDX_W-1:0] best_idx;

    // scanning downward with >= leaves the lowest index among equals
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (to_lvl(prio[i]) > cur_lvl) && (to_lvl(prio[i]) >= best_lvl)) begin
                best_lvl = to_lvl(prio[i]);
                best_idx = IDX_W'(i);
            end
        end
    end

    assign win_valid = (best_lvl != '0);
    assign win_idx   = best_idx;
    assign win_lvl   = best_lvl;

    AST_WIN_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_lvl > cur_lvl)) else $error("winner not above current level"); // R8
    AST_WIN_IS_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> req[win_idx]) else $error("winner not requesting"); // R3

endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack #(
    parameter int ENT_W = 9,
    parameter int DEPTH = 8,
    localparam int DEP_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [ENT_W-1:0] push_data,
    output logic [ENT_W-1:0] top_data,
    output logic [DEP_W-1:0] depth,
    output logic             empty,
    output logic             full
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [DEP_W-1:0] depth_q;

    assign empty = (depth_q == '0);
    assign full  = (depth_q == DEP_W'(DEPTH));
    assign depth = depth_q;
    assign top_data = empty ? '0 : mem[PTR_W'(depth_q - DEP_W'(1))];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (push && !full) begin
            mem[PTR_W'(depth_q)] <= push_data;
            depth_q <= depth_q + DEP_W'(1);
        end else if (pop && !empty) begin
            depth_q <= depth_q - DEP_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (depth_q == DEP_W'(DEPTH))) else $error("push on full stack"); // R12
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (depth_q == '0)) else $error("pop on empty stack"); // R12

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int PRIO_W      = 3,
    parameter int DATA_W      = 32,
    parameter int STACK_DEPTH = 8,
    localparam int IDX_W      = $clog2(NUM_SRC),
    localparam int ADDR_W     = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);

    localparam int LVL_W = PRIO_W + 1;
    localparam int ENT_W = LVL_W + IDX_W;
    localparam int DEP_W = $clog2(STACK_DEPTH + 1);

    // ---------------- bus decode ----------------
    logic [1:0]       region;
    logic [IDX_W-1:0] idx;
    logic             wr_mode, wr_vec, wr_spur, acc_ack, acc_eoi;

    assign region  = bus_addr[ADDR_W-1 -: 2];
    assign idx     = bus_addr[IDX_W-1:0];
    assign wr_mode = bus_wr && (region == RG_MODE);
    assign wr_vec  = bus_wr && (region == RG_VEC);
    assign wr_spur = bus_wr && (region == RG_CTRL) && (idx == IDX_W'(CTL_SPUR));
    assign acc_ack = bus_rd && (region == RG_CTRL) && (idx == IDX_W'(CTL_IVR));
    assign acc_eoi = bus_wr && (region == RG_CTRL) && (idx == IDX_W'(CTL_EOI));

    // ---------------- sources ----------------
    logic [NUM_SRC-1:0]             req, en_v, edge_v;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
    logic [NUM_SRC-1:0][DATA_W-1:0] vec_v;
    logic                           win_valid;
    logic [IDX_W-1:0]               win_idx;
    logic [LVL_W-1:0]               win_lvl;
    logic                           stk_push, stk_pop;

    irqc_src_bank #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .wr_mode (wr_mode),
        .wr_vec  (wr_vec),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .clr_en  (stk_push),
        .clr_idx (win_idx),
        .req_o   (req),
        .en_o    (en_v),
        .edge_o  (edge_v),
        .prio_o  (prio_v),
        .vec_o   (vec_v)
    );

    // ---------------- current context ----------------
    logic [LVL_W-1:0] cur_lvl;
    logic [IDX_W-1:0] cur_src;

    irqc_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .prio      (prio_v),
        .cur_lvl   (cur_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    logic [ENT_W-1:0] stk_top;
    logic [DEP_W-1:0] stk_depth;
    logic             stk_empty, stk_full;

    irqc_nest_stack #(
        .ENT_W(ENT_W), .DEPTH(STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data ({cur_lvl, cur_src}),
        .top_data  (stk_top),
        .depth     (stk_depth),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    // ---------------- nesting state machine ----------------
    nest_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stk_push) state_d = ST_SERVICE;                           // ACK_FIRST
            end
            ST_SERVICE: begin
                if (stk_push && stk_depth == DEP_W'(STACK_DEPTH - 1)) begin
                    state_d = ST_FULL;                                        // ACK_NEST to FULL
                end else if (stk_pop && stk_depth == DEP_W'(1)) begin
                    state_d = ST_IDLE;                                        // EOI_LAST
                end
            end
            ST_FULL: begin
                if (stk_pop) state_d = ST_SERVICE;                            // EOI_FULL
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine: stack commands
    always_comb begin
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                stk_push = acc_ack && win_valid;
            end
            ST_SERVICE: begin
                stk_push = acc_ack && win_valid;
                stk_pop  = acc_eoi && !acc_ack;
            end
            ST_FULL: begin
                stk_pop  = acc_eoi && !acc_ack;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= '0;
            cur_src <= '0;
        end else if (stk_push) begin
            cur_lvl <= win_lvl;
            cur_src <= win_idx;
        end else if (stk_pop) begin
            cur_lvl <= stk_top[ENT_W-1 -: LVL_W];
            cur_src <= stk_top[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= !win_valid;
        end
    end

    // ---------------- register file read side ----------------
    logic [DATA_W-1:0] spur_q;
    logic [DATA_W-1:0] mode_word, status_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spur_q <= '0;
        end else if (wr_spur) begin
            spur_q <= bus_wdata;
        end
    end

    always_comb begin
        mode_word = '0;
        mode_word[PRIO_W-1:0]    = prio_v[idx];
        mode_word[MODE_EDGE_BIT] = edge_v[idx];
        mode_word[MODE_EN_BIT]   = en_v[idx];
    end

    always_comb begin
        status_word = '0;
        status_word[IDX_W-1:0]               = cur_src;
        status_word[ST_PRIO_LSB +: PRIO_W]   = (cur_lvl == '0) ? '0 : PRIO_W'(cur_lvl - LVL_W'(1));
        status_word[ST_VALID_BIT]            = (cur_lvl != '0);
        status_word[ST_DEPTH_LSB +: DEP_W]   = stk_depth;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (region)
                RG_MODE: bus_rdata <= mode_word;
                RG_VEC:  bus_rdata <= vec_v[idx];
                RG_CTRL: begin
                    if (idx == IDX_W'(CTL_IVR)) begin
                        bus_rdata <= stk_push ? vec_v[win_idx] : spur_q;
                    end else if (idx == IDX_W'(CTL_SPUR)) begin
                        bus_rdata <= spur_q;
                    end else if (idx == IDX_W'(CTL_STATUS)) begin
                        bus_rdata <= status_word;
                    end else begin
                        bus_rdata <= '0;
                    end
                end
                default: bus_rdata <= '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_ACK_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> (cur_lvl > $past(cur_lvl))) else $error("acknowledge did not raise level"); // R7
    AST_EOI_LOWERS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |=> (cur_lvl < $past(cur_lvl))) else $error("end of interrupt did not lower level"); // R9
    AST_SPUR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ack && !win_valid) |=> (stk_depth == $past(stk_depth))) else $error("spurious read changed depth"); // R11
    AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) == stk_empty) else $error("state and stack disagree"); // R7
    AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == stk_full) else $error("full state and stack disagree"); // R12

endmodule

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;

    localparam logic [6:0] A_IVR  = 7'd64;
    localparam logic [6:0] A_EOI  = 7'd65;
    localparam logic [6:0] A_SPUR = 7'd66;
    localparam logic [6:0] A_STAT = 7'd67;
    localparam logic [31:0] SPUR_V = 32'hDEAD_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        chk_arm = 1'b0;

    always #4 clk = ~clk;

    nested_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    function automatic logic [31:0] vec_of(input int i);
        return 32'h4000_0000 | (i << 4);
    endfunction

    function automatic logic [31:0] stat(input int s, input int p, input int v, input int d);
        return (d << 16) | (v << 12) | (p << 8) | s;
    endfunction

    // monitor: compares registered read data against the scoreboard
    always @(posedge clk) chk_arm <= bus_rd;
    always @(negedge clk) begin
        if (chk_arm && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: bus_rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [6:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_checks++;
        if (irq_n !== e) begin
            n_fail++;
            $display("FAIL %s: irq_n actual=%b expected=%b", t, irq_n, e);
        end
    endtask

    task automatic cfg(input int i, input int p, input int edg, input int en);
        bus_write(7'(i), 32'(p) | (32'(edg) << 4) | (32'(en) << 8));
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk);
        src[i] = v;
    endtask

    task automatic eoi();
        bus_write(A_EOI, 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk_irq(1'b1, "R1 reset irq_n");
        rd_expect(A_STAT, 32'h0, "R1 reset status");
        rd_expect(A_IVR, 32'h0, "R1 reset spurious vector");

        for (int i = 1; i < 32; i++) bus_write(7'(32 + i), vec_of(i));
        bus_write(A_SPUR, SPUR_V);
        rd_expect(A_SPUR, SPUR_V, "R11 spurious readback");
        rd_expect(7'(32 + 7), vec_of(7), "R6 vector readback");

        // R3 disabled source
        cfg(5, 6, 0, 0);
        set_src(5, 1'b1);
        wait_cyc(4);
        chk_irq(1'b1, "R3 disabled source keeps irq_n high");
        rd_expect(A_IVR, SPUR_V, "R3 disabled source not selected");
        rd_expect(A_STAT, 32'h0, "R11 spurious read no push");

        // R2 level source
        cfg(5, 3, 0, 1);
        rd_expect(7'd5, 32'h103, "R6 mode readback");
        wait_cyc(3);
        chk_irq(1'b0, "R2 enabled level source asserts irq_n");
        rd_expect(A_IVR, vec_of(5), "R6 vector of source 5");
        rd_expect(A_STAT, stat(5, 3, 1, 1), "R7 status after acknowledge");
        wait_cyc(2);
        chk_irq(1'b1, "R8 in-service level holds irq_n high");
        cfg(9, 3, 1, 1);
        cfg(12, 2, 0, 1);
        set_src(9, 1'b1);
        set_src(9, 1'b0);
        set_src(12, 1'b1);
        wait_cyc(3);
        chk_irq(1'b1, "R8 equal and lower requests held off");
        eoi();
        rd_expect(A_STAT, 32'h0, "R9 status restored to none");
        wait_cyc(2);
        chk_irq(1'b0, "R9 held requests reassert irq_n");
        rd_expect(A_IVR, vec_of(5), "R5 lowest index wins among equals");
        eoi();
        set_src(5, 1'b0);
        wait_cyc(3);
        rd_expect(A_IVR, vec_of(9), "R10 edge pending after input fell");
        eoi();
        rd_expect(A_IVR, vec_of(12), "R10 level source pending while high");
        eoi();
        set_src(12, 1'b0);
        wait_cyc(3);
        chk_irq(1'b1, "R10 edge cleared by acknowledge");
        rd_expect(A_IVR, SPUR_V, "R11 nothing eligible");
        rd_expect(A_STAT, 32'h0, "R11 depth unchanged");

        // R4 choice at read time, nesting
        cfg(20, 1, 0, 1);
        cfg(30, 6, 0, 1);
        cfg(2, 7, 1, 1);
        set_src(20, 1'b1);
        wait_cyc(3);
        chk_irq(1'b0, "R2 source 20 raises request");
        set_src(30, 1'b1);
        wait_cyc(2);
        rd_expect(A_IVR, vec_of(30), "R4 later higher source wins");
        rd_expect(A_STAT, stat(30, 6, 1, 1), "R7 source 30 current");
        set_src(2, 1'b1);
        set_src(2, 1'b0);
        wait_cyc(2);
        chk_irq(1'b0, "R8 strictly higher priority reasserts");
        rd_expect(A_IVR, vec_of(2), "R7 nested acknowledge");
        rd_expect(A_STAT, stat(2, 7, 1, 2), "R7 depth two");
        eoi();
        rd_expect(A_STAT, stat(30, 6, 1, 1), "R9 previous context restored");
        set_src(30, 1'b0);
        eoi();
        wait_cyc(3);
        chk_irq(1'b0, "R9 held low-priority request returns");
        rd_expect(A_IVR, vec_of(20), "R9 source 20 served after pop");
        set_src(20, 1'b0);
        eoi();
        rd_expect(A_STAT, 32'h0, "R9 back to none");

        // R12 pop on empty
        eoi();
        rd_expect(A_STAT, 32'h0, "R12 pop on empty ignored");
        chk_irq(1'b1, "R12 irq_n after empty pop");

        // R12 full nesting ladder
        for (int k = 0; k < 8; k++) cfg(21 + k, k, 0, 1);
        for (int k = 0; k < 8; k++) begin
            set_src(21 + k, 1'b1);
            wait_cyc(3);
            chk_irq(1'b0, "R8 ladder step raises request");
            rd_expect(A_IVR, vec_of(21 + k), "R7 ladder acknowledge");
        end
        rd_expect(A_STAT, stat(28, 7, 1, 8), "R12 stack full at depth eight");
        rd_expect(A_IVR, SPUR_V, "R11 read while full is spurious");
        rd_expect(A_STAT, stat(28, 7, 1, 8), "R12 depth stays eight");
        for (int k = 0; k < 8; k++) set_src(21 + k, 1'b0);
        eoi();
        rd_expect(A_STAT, stat(27, 6, 1, 7), "R9 pop from full restores");
        for (int k = 0; k < 7; k++) eoi();
        rd_expect(A_STAT, 32'h0, "R9 ladder unwound");
        eoi();
        rd_expect(A_STAT, 32'h0, "R12 extra pop ignored");

        wait_cyc(3);
        done = 1;
        summary();
        $finish;
    end

endmodule